// File: doc/BRIEF.md
# Cascaded Wavelet Lowpass Decimator

This block splits the approximation path of a wavelet decomposition off a stream of signed 16-bit samples. A chain of identical stages each applies a four-tap lowpass filter built from the Daubechies D4 scaling coefficients, then keeps every second result. The chain has four stages, so its outputs run at one half, one quarter, one eighth and one sixteenth of the input sample rate. A producer presents samples with a valid strobe that may drop at any time. Downstream logic reads the four result streams, and each stream carries its own one-cycle valid strobe.

Rate reduction is not a separate stage. Each level accepts a sample whenever the level above it marks one valid. A level produces a result only on every second sample it accepts. Relative to the input, the four levels therefore fire on every 2nd, 4th, 8th and 16th accepted sample. Filter arithmetic uses Q1.15 coefficients and a wide accumulator. The result is rounded and clipped back to 16 bits.

Top module: `wl_decim_bank`

## Requirements
- R1: While reset is asserted, every output valid is 0 and every output data word is 0.
- R2: A level emits exactly one result for every two samples it accepts, on the second one. Its valid is never high in two consecutive cycles.
- R3: Level k+1 accepts only the results that level k marks valid. Sixteen accepted input samples after reset therefore give exactly 8, 4, 2 and 1 results on levels 1 to 4.
- R4: A result is y = 15826*x[n] + 27411*x[n-1] + 7345*x[n-2] - 4240*x[n-3]. Here x[n] is the sample accepted in the same cycle and x[n-1..n-3] are the level's earlier accepted samples. All values are signed two's complement, and the coefficients are in Q1.15.
- R5: The sum is scaled by adding 16384 and then shifting arithmetically right by 15. A half LSB therefore rounds toward plus infinity: 13705.5 gives 13706 and -13705.5 gives -13705.
- R6: A scaled value above 32767 is output as 32767, and a value below -32768 is output as -32768.
- R7: Level 1 raises its valid in the first cycle after the clock edge that accepts the sample completing its pair. Each further level adds one more cycle.
- R8: Input data presented while in_vld is low has no effect on any output or on later results.
- R9: Reset clears all sample history to zero and restarts the pairing. The first level-1 result after reset comes on the second accepted sample, and it uses only the samples accepted after reset.
- R10: A level's output data word changes only in cycles where its valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_vld | input | 1 | Input sample valid |
| in_data | input | DATA_W | Signed input sample |
| lvl_vld | output | LEVELS | Per-level result valid, bit k for level k+1 |
| lvl_data | output | LEVELS*DATA_W | Per-level signed result, bits [k*DATA_W +: DATA_W] for level k+1 |

## Verification
The hardest situation to reach is a level-4 result whose inputs carry the history of many irregularly spaced input samples. Reaching it needs sixteen accepted samples for each level-4 result. The accepted samples must also arrive between idle cycles that carry junk data. The bench drives long pseudo-random streams with a pseudo-random valid pattern. It checks every result of every level against a behavioural model of the cascade that is fed only accepted samples. Two further cases get dedicated short sequences: a reset in the middle of a stream that leaves a level halfway through a pair, and exact half-LSB values for rounding.

// File: rtl/wl_pkg.sv
package wl_pkg;
  // Coefficient format: signed Q1.15
  localparam int COEF_W = 16;
  localparam int FRAC_W = COEF_W - 1;
  localparam int NTAPS  = 4;
  // D4 scaling filter taps, index 0 multiplies the newest sample
  localparam logic signed [COEF_W-1:0] LP_COEF [NTAPS] =
    '{16'sd15826, 16'sd27411, 16'sd7345, -16'sd4240};
endpackage

// File: rtl/wl_mac.sv
module wl_mac
  import wl_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] tap_i [NTAPS],
  output logic signed [DATA_W-1:0] y_o
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int ACC_W  = PROD_W + 2;
  localparam logic signed [ACC_W-1:0] RND_HALF =
    {{(ACC_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] SAT_HI =
    {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO =
    {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod [NTAPS];
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  scaled;

  for (genvar k = 0; k < NTAPS; k++) begin : g_prod
    assign prod[k] = PROD_W'(tap_i[k]) * PROD_W'(LP_COEF[k]);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAPS; k++) begin
      acc = acc + ACC_W'(prod[k]);
    end
    scaled = (acc + RND_HALF) >>> FRAC_W;
    if (scaled > SAT_HI) begin
      y_o = SAT_HI[DATA_W-1:0];
    end else if (scaled < SAT_LO) begin
      y_o = SAT_LO[DATA_W-1:0];
    end else begin
      y_o = scaled[DATA_W-1:0];
    end
  end

  // R6: clipping must keep the sign of the scaled sum
  always_comb begin
    assert_sign_kept_R6: assert (y_o[DATA_W-1] == scaled[ACC_W-1])
      else $error("R6 clipped result changed sign");
  end
endmodule

// File: rtl/wl_stage.sv
module wl_stage
  import wl_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     in_vld_i,
  input  logic signed [DATA_W-1:0] in_data_i,
  output logic                     out_vld_o,
  output logic signed [DATA_W-1:0] out_data_o
);
  localparam int HIST_N = NTAPS - 1;

  logic signed [DATA_W-1:0] hist_q [HIST_N];
  logic signed [DATA_W-1:0] hist_d [HIST_N];
  logic                     phase_q, phase_d;
  logic                     vld_q, vld_d;
  logic signed [DATA_W-1:0] data_q, data_d;
  logic signed [DATA_W-1:0] taps [NTAPS];
  logic signed [DATA_W-1:0] fir_y;

  assign taps[0] = in_data_i;
  for (genvar k = 1; k < NTAPS; k++) begin : g_taps
    assign taps[k] = hist_q[k-1];
  end

  wl_mac #(.DATA_W(DATA_W)) u_mac (
    .tap_i (taps),
    .y_o   (fir_y)
  );

  // next state
  always_comb begin
    hist_d  = hist_q;
    phase_d = phase_q;
    vld_d   = 1'b0;
    data_d  = data_q;
    if (in_vld_i) begin
      hist_d[0] = in_data_i;
      for (int k = 1; k < HIST_N; k++) begin
        hist_d[k] = hist_q[k-1];
      end
      phase_d = ~phase_q;
      if (phase_q) begin
        vld_d  = 1'b1;
        data_d = fir_y;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '{default: '0};
      phase_q <= 1'b0;
      vld_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (in_vld_i) begin
        hist_q  <= hist_d;
        phase_q <= phase_d;
      end
      if (vld_d) begin
        data_q <= data_d;
      end
    end
  end

  assign out_vld_o  = vld_q;
  assign out_data_o = data_q;

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    out_vld_o |=> !out_vld_o)
    else $error("R2 valid high on consecutive cycles");

  assert_pair_latency_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_vld_i && phase_q) |=> out_vld_o)
    else $error("R7 completed pair gave no result next cycle");

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    !out_vld_o |-> $stable(out_data_o))
    else $error("R10 data changed without valid");
endmodule

// File: rtl/wl_decim_bank.sv
module wl_decim_bank
  import wl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEVELS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_vld,
  input  logic [DATA_W-1:0]          in_data,
  output logic [LEVELS-1:0]          lvl_vld,
  output logic [LEVELS*DATA_W-1:0]   lvl_data
);
  logic [1:0] rst_pipe;
  logic       rst_ni;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_ni = rst_pipe[1];

  logic                     chain_vld [LEVELS+1];
  logic signed [DATA_W-1:0] chain_dat [LEVELS+1];

  assign chain_vld[0] = in_vld;
  assign chain_dat[0] = $signed(in_data);

  for (genvar k = 0; k < LEVELS; k++) begin : g_level
    wl_stage #(.DATA_W(DATA_W)) u_stage (
      .clk        (clk),
      .rst_ni     (rst_ni),
      .in_vld_i   (chain_vld[k]),
      .in_data_i  (chain_dat[k]),
      .out_vld_o  (chain_vld[k+1]),
      .out_data_o (chain_dat[k+1])
    );
    assign lvl_vld[k]                   = chain_vld[k+1];
    assign lvl_data[k*DATA_W +: DATA_W] = chain_dat[k+1];

    if (k > 0) begin : g_casc_chk
      assert_cascade_R3: assert property (@(posedge clk) disable iff (!rst_ni)
        lvl_vld[k] |-> $past(lvl_vld[k-1]))
        else $error("R3 level result without upstream result");
    end
  end
endmodule

// File: tb/tb_wl_decim_bank.sv
module tb_wl_decim_bank;
  localparam int DW = 16;
  localparam int NL = 4;
  localparam int C0 = 15826, C1 = 27411, C2 = 7345, C3 = -4240;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_vld = 1'b0;
  logic [DW-1:0]     in_data = '0;
  logic [NL-1:0]     lvl_vld;
  logic [NL*DW-1:0]  lvl_data;

  always #10 clk = ~clk;

  wl_decim_bank #(.DATA_W(DW), .LEVELS(NL)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .lvl_vld(lvl_vld), .lvl_data(lvl_data)
  );

  int n_chk = 0;
  int n_err = 0;
  bit mon_en = 1'b0;
  int m_hist [NL][3];
  bit m_ph [NL];
  int m_q [NL][$];
  int held [NL];
  int n_out [NL];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int fir_ref(int x0, int x1, int x2, int x3);
    longint acc;
    acc = longint'(x0) * C0 + longint'(x1) * C1 + longint'(x2) * C2 + longint'(x3) * C3;
    acc = (acc + 16384) >>> 15;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  function automatic void mdl_clear();
    for (int k = 0; k < NL; k++) begin
      m_q[k].delete();
      m_ph[k] = 1'b0;
      held[k] = 0;
      n_out[k] = 0;
      for (int j = 0; j < 3; j++) m_hist[k][j] = 0;
    end
  endfunction

  function automatic void mdl_feed(int s);
    int v;
    v = s;
    for (int k = 0; k < NL; k++) begin
      int y;
      bit fire;
      fire = m_ph[k];
      y = fir_ref(v, m_hist[k][0], m_hist[k][1], m_hist[k][2]);
      m_hist[k][2] = m_hist[k][1];
      m_hist[k][1] = m_hist[k][0];
      m_hist[k][0] = v;
      m_ph[k] = !m_ph[k];
      if (!fire) break;
      m_q[k].push_back(y);
      v = y;
    end
  endfunction

  function automatic int l_dat(int k);
    return int'($signed(lvl_data[k*DW +: DW]));
  endfunction

  function automatic void lfsr_step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endfunction

  // result monitor: every result against the model (R4, R5, R6), hold (R10)
  always @(negedge clk) begin
    if (mon_en) begin
      for (int k = 0; k < NL; k++) begin
        if (lvl_vld[k]) begin
          n_out[k]++;
          if (m_q[k].size() == 0) chk("R3 unexpected result", 1, 0);
          else chk("R4 result value", l_dat(k), m_q[k].pop_front());
          held[k] = l_dat(k);
        end else begin
          chk("R10 data held", l_dat(k), held[k]);
        end
      end
    end
  end

  task automatic feed(bit v, int d);
    @(negedge clk);
    in_vld = v;
    in_data = d[DW-1:0];
    if (v) mdl_feed(d);
  endtask

  task automatic drain();
    repeat (8) feed(1'b0, 16'hBEEF);
    for (int k = 0; k < NL; k++) chk("R3 missing results", m_q[k].size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    mon_en = 1'b0;
    rst_n = 1'b0;
    in_vld = 1'b0;
    in_data = '0;
    repeat (2) @(negedge clk);
    chk("R1 valid in reset", int'(lvl_vld), 0);
    chk("R1 data in reset", (lvl_data == '0) ? 0 : 1, 0);
    mdl_clear();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_en = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 valid after reset", int'(lvl_vld), 0);
  endtask

  task automatic t_first_result();
    do_reset();
    feed(1'b1, 1000);
    feed(1'b1, 2000);
    chk("R2 no result on first sample", int'(lvl_vld[0]), 0);
    feed(1'b0, 0);
    chk("R7 level1 valid one cycle after pair", int'(lvl_vld[0]), 1);
    chk("R4 first level1 value", l_dat(0), 1802);
    chk("R3 deeper levels idle", int'(lvl_vld[NL-1:1]), 0);
    feed(1'b0, 0);
    chk("R2 single pulse", int'(lvl_vld[0]), 0);
    drain();
  endtask

  task automatic t_counts();
    do_reset();
    for (int i = 0; i < 16; i++) begin
      feed(1'b1, int'($signed(lfsr)));
      lfsr_step();
    end
    drain();
    chk("R3 level1 count", n_out[0], 8);
    chk("R3 level2 count", n_out[1], 4);
    chk("R3 level3 count", n_out[2], 2);
    chk("R3 level4 count", n_out[3], 1);
  endtask

  task automatic t_rounding();
    do_reset();
    feed(1'b1, 16384);
    feed(1'b1, 0);
    feed(1'b0, 0);
    chk("R5 positive half rounds up", l_dat(0), 13706);
    drain();
    do_reset();
    feed(1'b1, -16384);
    feed(1'b1, 0);
    feed(1'b0, 0);
    chk("R5 negative half rounds up", l_dat(0), -13705);
    drain();
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 4; i++) feed(1'b1, 32767);
    feed(1'b0, 0);
    chk("R6 high clip", l_dat(0), 32767);
    for (int i = 0; i < 20; i++) feed(1'b1, 32767);
    drain();
    do_reset();
    for (int i = 0; i < 4; i++) feed(1'b1, -32768);
    feed(1'b0, 0);
    chk("R6 low clip", l_dat(0), -32768);
    for (int i = 0; i < 20; i++) feed(1'b1, -32768);
    drain();
  endtask

  task automatic t_gaps();
    int acc_n;
    acc_n = 0;
    do_reset();
    for (int i = 0; i < 200; i++) begin
      bit v;
      v = lfsr[3] | lfsr[7];
      if (v) acc_n++;
      feed(v, int'($signed(lfsr)));
      lfsr_step();
    end
    drain();
    chk("R8 level1 count with gaps", n_out[0], acc_n / 2);
  endtask

  task automatic t_mid_reset();
    do_reset();
    feed(1'b1, 5000);
    feed(1'b1, -7000);
    feed(1'b1, 12000);
    do_reset();
    feed(1'b1, 16384);
    chk("R9 no result on first sample after reset", int'(lvl_vld[0]), 0);
    feed(1'b1, 0);
    feed(1'b0, 0);
    chk("R9 pairing restarted", int'(lvl_vld[0]), 1);
    chk("R9 history cleared", l_dat(0), 13706);
    drain();
  endtask

  initial begin
    t_reset_state();
    t_first_result();
    t_counts();
    t_rounding();
    t_saturate();
    t_gaps();
    t_mid_reset();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule